// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM alive. A free-running timer divides the retention period evenly across all rows and marks one refresh as due each time an interval ends. The scheduler then asks the access arbiter for the memory bus. When the bus is granted, it drives the row strobe, column strobe and address lines through one complete refresh cycle, and then hands the bus back.

Two refresh methods are available, chosen by a mode input. In row-addressed mode, the block keeps its own row counter, puts that row on the address lines, and pulses the row strobe low while the column strobe stays high. In counter-in-device mode, the column strobe falls first and the row strobe follows. The device then uses its internal counter and ignores the address lines. In counter-in-device mode a hidden refresh can also be taken. At the end of a read that leaves the column strobe low, the arbiter signals a handover. The block keeps the column strobe low so the read data stays valid, precharges with the row strobe high, and then pulls the row strobe low again.

Refreshes that are due but not yet served accumulate in a bounded backlog, so a delayed grant does not lose them.

Top module: `rfsh_sched`

## Requirements
- R1: A refresh becomes due every TINT = CLK_MHZ*RET_US/ROWS clock cycles, counted by a free-running timer. The first request appears about TINT cycles after reset.
- R2: While a refresh is due and no grant has arrived, `req` stays high, `bus_own` stays low, and `ras_n` and `cas_n` stay high.
- R3: In row-addressed mode (`mode_cbr`=0), `cas_n` is high when `ras_n` falls, and `ras_n` stays low for exactly TRAS_CYC cycles.
- R4: In row-addressed mode, `addr` carries the row counter while `ras_n` falls. The counter advances by one after each such refresh, wrapping from ROWS-1 to 0, so every row appears exactly once per sweep of ROWS refreshes.
- R5: In counter-in-device mode (`mode_cbr`=1), `cas_n` goes low exactly TCSR_CYC cycles before `ras_n` falls. The row counter and `addr` do not change.
- R6: In counter-in-device mode, a `hid_ok` pulse while a refresh is due starts a hidden refresh without a grant. The next cycle shows `cas_n` low, `ras_n` high and `bus_own` high. `cas_n` then stays low for TRP_CYC cycles before `ras_n` falls.
- R7: `ras_n` is high for at least TRP_CYC cycles before every falling edge. After every rising edge it stays high for TRP_CYC cycles before `bus_own` drops.
- R8: Intervals that end while refreshes are waiting add to a backlog of at most MAX_PEND. Once the grant returns, exactly that many refreshes run back to back, and further due refreshes are dropped while the backlog is full.
- R9: `mode_cbr` is sampled only while the block is idle. A change while a request is pending does not affect that refresh.
- R10: During reset, `req` and `bus_own` are low, `ras_n` and `cas_n` are high, and `addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cbr | input | 1 | 0 = row-addressed refresh, 1 = counter-in-device refresh |
| gnt | input | 1 | Bus grant from the arbiter |
| hid_ok | input | 1 | Handover pulse at the end of a read with the column strobe held low |
| req | output | 1 | Refresh request to the arbiter |
| bus_own | output | 1 | The block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr | output | ROW_W | Row address |

## Verification
A wrong row counter shows on `addr` at the very next row-addressed strobe fall, as a skipped, repeated or unwrapped row within one sweep. A wrong phase counter in the sequencer shows within one refresh as a row-strobe low width other than TRAS_CYC, or as a column-strobe lead other than TCSR_CYC or TRP_CYC. A wrong backlog count, such as a missing saturation or a lost decrement, shows only after a stall, as a burst of back-to-back refreshes whose length differs from MAX_PEND. A mode captured outside idle shows on the first refresh after the change, as the wrong strobe order.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_PRE,
    ST_LEAD,
    ST_ACT,
    ST_POST
  } rfsh_st_e;
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int TINT = 781,
  localparam int CW = (TINT > 1) ? $clog2(TINT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == CW'(TINT - 1));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // A due refresh is marked once per interval and never in two cycles in a row
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int MAXP = 8,
  localparam int PW = $clog2(MAXP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic done,
  output logic pend_any
);
  logic [PW-1:0] pend_q, pend_d;
  logic          inc;
  logic          full;

  assign full     = (pend_q == PW'(MAXP));
  assign pend_any = (pend_q != '0);
  // A full backlog still accepts a new refresh in the cycle one completes
  assign inc      = tick && (!full || done);

  always_comb begin
    pend_d = pend_q;
    if (inc && !done)      pend_d = pend_q + 1'b1;
    else if (!inc && done) pend_d = pend_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_d_wr: pend_q <= pend_d;
  end

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && tick && !done) |=> full);
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pend_any);
endmodule

// File: rtl/rfsh_rowctr.sv
module rfsh_rowctr #(
  parameter int ROWS = 8192,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [RW-1:0] row
);
  logic [RW-1:0] row_q, row_d;
  logic          last;

  assign last = (row_q == RW'(ROWS - 1));
  assign row  = row_q;

  always_comb begin
    row_d = row_q;
    if (adv) row_d = last ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  p_row_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(row_q));
  p_row_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= RW'(ROWS - 1));
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int TRP  = 4,
  parameter int TRAS = 6,
  parameter int TCSR = 1,
  localparam int MAXT = (TRP > TRAS) ? ((TRP > TCSR) ? TRP : TCSR)
                                     : ((TRAS > TCSR) ? TRAS : TCSR),
  localparam int CW   = $clog2(MAXT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_cbr,
  input  logic pend_any,
  input  logic gnt,
  input  logic hid_ok,
  output logic req,
  output logic done,
  output logic adv,
  output logic ras_n,
  output logic cas_n,
  output logic bus_own
);
  rfsh_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mode_q, mode_d;
  logic          hid_q, hid_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    hid_d  = hid_q;
    unique case (st_q)
      ST_IDLE: begin
        if (pend_any) begin
          mode_d = mode_cbr;
          if (hid_ok && mode_cbr) begin
            st_d  = ST_PRE;
            hid_d = 1'b1;
            cnt_d = CW'(TRP - 1);
          end else begin
            st_d  = ST_REQ;
            hid_d = 1'b0;
          end
        end
      end
      ST_REQ: begin
        if (hid_ok && mode_q) begin
          st_d  = ST_PRE;
          hid_d = 1'b1;
          cnt_d = CW'(TRP - 1);
        end else if (gnt) begin
          st_d  = ST_PRE;
          hid_d = 1'b0;
          cnt_d = CW'(TRP - 1);
        end
      end
      ST_PRE: begin
        if (!cnt_zero) cnt_d = cnt_q - 1'b1;
        else if (mode_q && !hid_q) begin
          st_d  = ST_LEAD;
          cnt_d = CW'(TCSR - 1);
        end else begin
          st_d  = ST_ACT;
          cnt_d = CW'(TRAS - 1);
        end
      end
      ST_LEAD: begin
        if (!cnt_zero) cnt_d = cnt_q - 1'b1;
        else begin
          st_d  = ST_ACT;
          cnt_d = CW'(TRAS - 1);
        end
      end
      ST_ACT: begin
        if (!cnt_zero) cnt_d = cnt_q - 1'b1;
        else begin
          st_d  = ST_POST;
          cnt_d = CW'(TRP - 1);
        end
      end
      ST_POST: begin
        if (!cnt_zero) cnt_d = cnt_q - 1'b1;
        else begin
          st_d  = ST_IDLE;
          hid_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      hid_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      hid_q  <= hid_d;
    end
  end

  assign req     = (st_q == ST_REQ);
  assign done    = (st_q == ST_POST) && cnt_zero;
  assign adv     = done && !mode_q;
  assign ras_n   = (st_q != ST_ACT);
  assign cas_n   = !(((st_q == ST_PRE) && hid_q) || (st_q == ST_LEAD) ||
                     ((st_q == ST_ACT) && mode_q));
  assign bus_own = (st_q == ST_PRE) || (st_q == ST_LEAD) ||
                   (st_q == ST_ACT) || (st_q == ST_POST);

  // Checker counters: consecutive cycles with the row strobe low or high
  logic [15:0] lo_run_q, hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run_q <= '0;
      hi_run_q <= 16'hffff;
    end else if (ras_n) begin
      lo_run_q <= '0;
      if (hi_run_q != 16'hffff) hi_run_q <= hi_run_q + 1'b1;
    end else begin
      hi_run_q <= '0;
      if (lo_run_q != 16'hffff) lo_run_q <= lo_run_q + 1'b1;
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt && !hid_ok) |=> req);
  p_no_drive_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (ras_n && cas_n && !bus_own));
  p_ras_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_run_q == 16'(TRAS)));
  p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_run_q >= 16'(TRP)));
  p_cas_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && mode_q) |-> (!cas_n && !$past(cas_n)));
  p_ror_cas_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !mode_q) |-> cas_n);
  p_mode_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(mode_q));
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int CLK_MHZ  = 100,
  parameter int RET_US   = 64000,
  parameter int ROWS     = 8192,
  parameter int MAX_PEND = 8,
  parameter int TRP_CYC  = 4,
  parameter int TRAS_CYC = 6,
  parameter int TCSR_CYC = 1,
  localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int TINT    = (CLK_MHZ * RET_US) / ROWS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_cbr,
  input  logic             gnt,
  input  logic             hid_ok,
  output logic             req,
  output logic             bus_own,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] addr
);
  logic rst_s1_q, rst_s2_q;
  logic tick, done, adv, pend_any;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  rfsh_timer #(.TINT(TINT)) u_timer (
    .clk (clk),
    .rst_n (rst_s2_q),
    .tick (tick)
  );

  rfsh_backlog #(.MAXP(MAX_PEND)) u_backlog (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .tick     (tick),
    .done     (done),
    .pend_any (pend_any)
  );

  rfsh_rowctr #(.ROWS(ROWS)) u_rowctr (
    .clk   (clk),
    .rst_n (rst_s2_q),
    .adv   (adv),
    .row   (addr)
  );

  rfsh_seq #(.TRP(TRP_CYC), .TRAS(TRAS_CYC), .TCSR(TCSR_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .mode_cbr (mode_cbr),
    .pend_any (pend_any),
    .gnt      (gnt),
    .hid_ok   (hid_ok),
    .req      (req),
    .done     (done),
    .adv      (adv),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .bus_own  (bus_own)
  );
endmodule

// File: tb/test_rfsh_sched.sv
module test_rfsh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 16;
  localparam int MAXP  = 4;
  localparam int TRP   = 3;
  localparam int TRAS  = 5;
  localparam int TCSR  = 2;
  localparam int TINT  = 100;
  localparam int RW    = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n, mode_cbr, gnt, hid_ok;
  logic req, bus_own, ras_n, cas_n;
  logic [RW-1:0] addr;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done_flag = 0;
  bit gnt_en = 0, gnt_fast = 0;
  bit exp_mode = 0, exp_hidden = 0;
  int exp_row = 0;
  int falls = 0, ror_falls = 0;
  int seen [ROWS];

  rfsh_sched #(.CLK_MHZ(100), .RET_US(16), .ROWS(ROWS), .MAX_PEND(MAXP),
               .TRP_CYC(TRP), .TRAS_CYC(TRAS), .TCSR_CYC(TCSR)) i_rfsh_sched (
    .clk(clk), .rst_n(rst_n), .mode_cbr(mode_cbr), .gnt(gnt), .hid_ok(hid_ok),
    .req(req), .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n), .addr(addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int next_row(int r);
    return (r + 1) % ROWS;
  endfunction

  function automatic int exp_lead(bit hidden);
    return hidden ? TRP : TCSR;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Grant responder with random latency
  initial begin
    gnt = 1'b0;
    forever begin
      @(negedge clk);
      gnt = 1'b0;
      if (gnt_en && req) begin
        if (!gnt_fast) repeat ($urandom % 3) @(negedge clk);
        gnt = 1'b1;
      end
    end
  end

  // Strobe monitor
  initial begin
    bit prev_ras = 1;
    int hi_run = 100, lo_run = 0, cas_lo_run = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_ras = 1; hi_run = 100; lo_run = 0; cas_lo_run = 0;
      end else begin
        if (prev_ras && !ras_n) begin
          falls++;
          chk(hi_run >= TRP, "R7 precharge before fall", hi_run, TRP);
          if (!exp_mode) begin
            chk(cas_n == 1'b1, "R3 cas high at fall", cas_n, 1);
            chk(int'(addr) == exp_row, "R4 row address", addr, exp_row);
            if (ror_falls < ROWS) seen[addr]++;
            ror_falls++;
            exp_row = next_row(exp_row);
          end else begin
            chk(cas_n == 1'b0, "R5 cas low at fall", cas_n, 0);
            chk(cas_lo_run == exp_lead(exp_hidden),
                exp_hidden ? "R6 hidden cas lead" : "R5 cas lead",
                cas_lo_run, exp_lead(exp_hidden));
            chk(int'(addr) == exp_row, "R5 row unchanged", addr, exp_row);
          end
        end
        if (!prev_ras && ras_n)
          chk(lo_run == TRAS, "R3 ras low width", lo_run, TRAS);
        if (ras_n) begin hi_run++; lo_run = 0; end
        else begin lo_run++; hi_run = 0; end
        cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
        prev_ras = ras_n;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  task automatic wait_idle();
    do @(negedge clk); while (req || bus_own);
  endtask

  initial begin
    int n, f0, bad;
    void'($urandom(32'h1d2e3f));
    rst_n = 0; mode_cbr = 0; hid_ok = 0;
    foreach (seen[i]) seen[i] = 0;
    repeat (3) @(negedge clk);
    // R10 reset values
    chk(req == 0, "R10 req", req, 0);
    chk(bus_own == 0, "R10 bus_own", bus_own, 0);
    chk(ras_n == 1, "R10 ras_n", ras_n, 1);
    chk(cas_n == 1, "R10 cas_n", cas_n, 1);
    chk(addr == 0, "R10 addr", addr, 0);
    rst_n = 1;

    // R1 first request near one interval
    n = 0;
    do begin @(negedge clk); n++; end while (!req && n < 3*TINT);
    chk(n >= TINT && n <= TINT + 4, "R1 first request", n, TINT + 3);

    // R4 row-addressed sweep with random grant latency
    gnt_en = 1;
    while (ror_falls < ROWS + 3) @(negedge clk);
    bad = 0;
    for (int i = 0; i < ROWS; i++) if (seen[i] != 1) bad++;
    chk(bad == 0, "R4 each row once per sweep", bad, 0);

    // R2 and R8: stall the grant, then release it just after an interval boundary
    wait_idle();
    gnt_en = 0;
    bad = 0;
    for (int i = 0; i < (MAXP + 2) * TINT; i++) begin
      @(negedge clk);
      if (req && (!ras_n || !cas_n || bus_own)) bad++;
    end
    chk(req == 1, "R2 request held", req, 1);
    chk(bad == 0, "R2 no drive while waiting", bad, 0);
    gnt_fast = 1;
    do @(negedge clk); while (cyc % TINT != 10);
    f0 = falls;
    gnt_en = 1;
    do @(negedge clk); while (cyc % TINT != 90);
    chk(falls - f0 == MAXP, "R8 backlog burst", falls - f0, MAXP);
    gnt_fast = 0;

    // R5 counter-in-device refreshes
    wait_idle();
    mode_cbr = 1; exp_mode = 1;
    f0 = falls;
    while (falls < f0 + 3) @(negedge clk);
    wait_idle();
    chk(int'(addr) == exp_row, "R5 address after device-counter refreshes", addr, exp_row);

    // R6 hidden refresh
    gnt_en = 0;
    do @(negedge clk); while (!req);
    exp_hidden = 1;
    hid_ok = 1;
    @(negedge clk);
    hid_ok = 0;
    chk(cas_n == 0, "R6 cas held low", cas_n, 0);
    chk(ras_n == 1, "R6 ras precharge", ras_n, 1);
    chk(bus_own == 1 && req == 0, "R6 taken without grant", bus_own, 1);
    f0 = falls;
    while (falls == f0) @(negedge clk);
    wait_idle();
    exp_hidden = 0;

    // R9 mode change while a request is pending
    mode_cbr = 0; exp_mode = 0;
    do @(negedge clk); while (!req);
    mode_cbr = 1;
    gnt_en = 1;
    f0 = falls;
    while (falls == f0) @(negedge clk);
    mode_cbr = 0;
    wait_idle();
    chk(int'(addr) == exp_row, "R9 latched mode advanced the row", addr, exp_row);

    summary();
  end
endmodule